// File: doc/BRIEF.md
# Pseudo-Random Pattern Memory Self-Test Controller

This controller runs a built-in self-test on a small synchronous single-port memory. A seven-bit linear feedback shift register produces a pseudo-random bit stream. In the fill phase the stream is packed one bit per cycle into a word register. Each complete word goes to the next address, starting at address zero. When the last address has been written, the same register is reloaded with the pass seed. The check phase then reads each word back, unpacks it one bit per cycle and compares every bit with a freshly regenerated stream bit.

The read latency and the unpacking order are fixed. Because of that, the controller always knows which word and which bit position is under comparison. Every mismatch is reported on a fail-log strobe together with its address and bit index, and a sticky fail flag is raised. Between passes, software applies a new seed, so the pattern sits at a different offset and every cell sees a different mix of neighbouring bits. The array holds more bits than one period of the sequence. The stream therefore keeps running across the period boundary without a restart, and generator and checker must keep exactly the same bit order.

Top module: `prbs_mbist`

## Requirements
- R1: The bit stream follows this rule. A seven-bit state s is loaded with the seed when a pass starts. Each new bit is b = s[6] XOR s[5], and after each bit the state becomes {s[5:0], b}.
- R2: In the fill phase, bit j of the word written to address a equals stream bit number a*DATA_W + j, counting from 0 (least significant bit first). Addresses are written in ascending order, and the stream runs on across its 127-bit period without restarting.
- R3: Each start loads the seed input. A zero seed is replaced by 7'h01, so a zero-seed pass writes the same contents as a seed-1 pass.
- R4: In the check phase, every stored bit is compared with the regenerated stream. Each differing bit produces exactly one single-cycle pulse on fail_valid.
- R5: fail_addr and fail_bit give the word address and bit position of the bit that produced the pulse. Reports come out in ascending address order and, within a word, lowest bit first.
- R6: fail goes high together with the first fail_valid pulse and stays high until the next accepted start, which clears it. After a pass with no mismatch, fail is low.
- R7: done goes high exactly 2 + WORDS*(2*DATA_W+3) clock edges after the edge that accepts start, counting that edge as the first (306 with the defaults). done stays high until the next start. busy is high from the cycle after start until done rises, and busy and done are never high together.
- R8: A start pulse while busy is high is ignored. It changes neither the seed, the memory contents nor the completion time.
- R9: While rst_n is low, busy, done, fail, fail_valid and mem_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a pass when the controller is idle or done |
| seed | input | 7 | Register seed for the pass |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the address |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | Pass finished and pipeline drained |
| fail | output | 1 | Sticky flag: at least one mismatch in this pass |
| fail_valid | output | 1 | One-cycle strobe per mismatching bit |
| fail_addr | output | ADDR_W | Address of the reported bit |
| fail_bit | output | $clog2(DATA_W) | Bit index of the reported bit |

## Verification
The hardest case to reach from the ports is a burst of several mismatches inside one word, or a mismatch on the very last bit of the last word. In the burst case the strobes come back to back. In the last-bit case the strobe lands one cycle before done. The bench's memory model XORs a per-address fault mask into the read path only. This leaves the written image clean, so it can be compared with the modelled stream, while the checker sees chosen multi-bit and boundary faults. A start pulse in the middle of the fill phase checks that a pass cannot be disturbed once it is running.

// File: rtl/prbs_mbist_pkg.sv
// Shared types for the memory self-test controller.
// Assumes: one state register per controller instance.
package prbs_mbist_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_RD,
        ST_WAIT,
        ST_LOAD,
        ST_SHIFT,
        ST_DRAIN,
        ST_DONE
    } mbist_state_t;
endpackage

// File: rtl/prbs_lfsr.sv
// Fibonacci shift register that yields one pseudo-random bit per step.
// The output bit is the feedback value of the current state.
// Assumes: TAP_A and TAP_B lie in 1..W; load wins over step; a zero seed becomes 1.
module prbs_lfsr #(
    parameter int W     = 7,
    parameter int TAP_A = 7,
    parameter int TAP_B = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic         bit_o
);
    logic [W-1:0] st_q;

    // feedback bit from the two taps
    assign bit_o = st_q[TAP_A-1] ^ st_q[TAP_B-1];

    // state update: reseed, advance or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= W'(1);
        end else if (load) begin
            st_q <= (seed == '0) ? W'(1) : seed;
        end else if (step) begin
            st_q <= {st_q[W-2:0], bit_o};
        end
    end
endmodule

// File: rtl/bist_s2p.sv
// Serial-to-parallel packer: the first bit shifted in ends at bit 0.
// word_o shows the word including the bit being shifted in this cycle.
// Assumes: the caller counts DW shifts per word.
module bist_s2p #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift,
    input  logic          bit_i,
    output logic [DW-1:0] word_o
);
    logic [DW-1:0] sr_q;

    // the word as it will be after this shift
    assign word_o = {bit_i, sr_q[DW-1:1]};

    // right shift, new bit enters at the top
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_q <= '0;
        else if (shift) sr_q <= word_o;
    end
endmodule

// File: rtl/bist_p2s.sv
// Parallel-to-serial unpacker: emits bit 0 first, then shifts right.
// Assumes: load and shift are never asserted together.
module bist_p2s #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] word_i,
    input  logic          shift,
    output logic          bit_o
);
    logic [DW-1:0] sr_q;

    assign bit_o = sr_q[0];

    // capture a word or move it one place toward bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_q <= '0;
        else if (load)  sr_q <= word_i;
        else if (shift) sr_q <= {1'b0, sr_q[DW-1:1]};
    end
endmodule

// File: rtl/prbs_mbist.sv
// Memory self-test controller: fills the memory with a pseudo-random
// stream, then reads it back and checks it bit by bit. Each mismatch is
// logged with its word address and bit index.
// Assumes: synchronous memory, writes at the clock edge, read data one
// cycle after the address; all memory outputs come from registers.
module prbs_mbist #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int LFSR_W = 7,
    parameter int TAP_A  = 7,
    parameter int TAP_B  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [LFSR_W-1:0]         seed,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    output logic                      mem_we,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      busy,
    output logic                      done,
    output logic                      fail,
    output logic                      fail_valid,
    output logic [ADDR_W-1:0]         fail_addr,
    output logic [$clog2(DATA_W)-1:0] fail_bit
);
    import prbs_mbist_pkg::*;

    localparam int                BIT_W     = $clog2(DATA_W);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);

    mbist_state_t        state_q;
    logic [ADDR_W-1:0]   word_q;
    logic [BIT_W-1:0]    bit_q;
    logic [LFSR_W-1:0]   seed_q;
    logic                start_ok;
    logic                fill_end;
    logic                lfsr_load;
    logic                lfsr_bit;
    logic [LFSR_W-1:0]   lfsr_seed;
    logic [DATA_W-1:0]   packed_word;
    logic                chk_bit;
    logic                mismatch;

    // start is honoured only when no pass is running
    assign start_ok  = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign fill_end  = (state_q == ST_FILL) && (bit_q == LAST_BIT) && (word_q == LAST_ADDR);
    assign lfsr_load = start_ok || fill_end;
    assign lfsr_seed = start_ok ? seed : seed_q;
    assign mismatch  = (state_q == ST_SHIFT) && (chk_bit != lfsr_bit);

    prbs_lfsr #(.W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (lfsr_load),
        .seed  (lfsr_seed),
        .step  (state_q == ST_FILL || state_q == ST_SHIFT),
        .bit_o (lfsr_bit)
    );

    bist_s2p #(.DW(DATA_W)) u_s2p (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (state_q == ST_FILL),
        .bit_i  (lfsr_bit),
        .word_o (packed_word)
    );

    bist_p2s #(.DW(DATA_W)) u_p2s (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state_q == ST_LOAD),
        .word_i (mem_rdata),
        .shift  (state_q == ST_SHIFT),
        .bit_o  (chk_bit)
    );

    // phase sequencing, word and bit counters, memory requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            word_q    <= '0;
            bit_q     <= '0;
            seed_q    <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_we    <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start_ok) begin
                        state_q <= ST_FILL;
                        seed_q  <= seed;
                        word_q  <= '0;
                        bit_q   <= '0;
                    end
                end
                ST_FILL: begin
                    bit_q <= bit_q + 1'b1;
                    if (bit_q == LAST_BIT) begin
                        bit_q     <= '0;
                        mem_we    <= 1'b1;
                        mem_addr  <= word_q;
                        mem_wdata <= packed_word;
                        word_q    <= word_q + 1'b1;
                        if (word_q == LAST_ADDR) state_q <= ST_RD;
                    end
                end
                ST_RD: begin
                    mem_addr <= word_q;
                    state_q  <= ST_WAIT;
                end
                ST_WAIT:  state_q <= ST_LOAD;
                ST_LOAD:  state_q <= ST_SHIFT;
                ST_SHIFT: begin
                    bit_q <= bit_q + 1'b1;
                    if (bit_q == LAST_BIT) begin
                        bit_q <= '0;
                        if (word_q == LAST_ADDR) begin
                            state_q <= ST_DRAIN;
                        end else begin
                            word_q  <= word_q + 1'b1;
                            state_q <= ST_RD;
                        end
                    end
                end
                ST_DRAIN: state_q <= ST_DONE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // fail log: the word and bit counters name the bit under comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail       <= 1'b0;
            fail_valid <= 1'b0;
            fail_addr  <= '0;
            fail_bit   <= '0;
        end else begin
            fail_valid <= mismatch;
            if (start_ok) begin
                fail <= 1'b0;
            end else if (mismatch) begin
                fail      <= 1'b1;
                fail_addr <= word_q;
                fail_bit  <= bit_q;
            end
        end
    end

    // status outputs straight from the state
    assign busy = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done = (state_q == ST_DONE);
endmodule

// File: rtl/prbs_mbist_chk.sv
// Property checker for the self-test controller, attached with bind.
module prbs_mbist_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic fail,
    input logic fail_valid,
    input logic mem_we
);
    // R6
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !start |=> fail);

    // R4
    strobe_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_valid |-> fail);

    // R7
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    // R8
    busy_runs_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> busy || done);

    // R2
    write_in_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
endmodule

bind prbs_mbist prbs_mbist_chk u_prbs_mbist_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .fail_valid (fail_valid),
    .mem_we     (mem_we)
);

// File: tb/prbs_mbist_tb_top.sv
`timescale 1ns/1ps
module prbs_mbist_tb_top;
    localparam int AW      = 4;
    localparam int DW      = 8;
    localparam int BW      = 3;
    localparam int WORDS   = 1 << AW;
    localparam int EXP_CYC = 2 + WORDS * (2 * DW + 3);
    localparam int NVEC    = 5;
    // vector layout: seed[18:12], fault address[11:8], fault mask[7:0]
    localparam logic [18:0] VEC [NVEC] = '{
        {7'h01, 4'd0,  8'h00},
        {7'h5A, 4'd3,  8'h01},
        {7'h33, 4'd15, 8'h80},
        {7'h7F, 4'd7,  8'hA5},
        {7'h00, 4'd0,  8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [6:0]    seed = 7'h01;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, fail, fail_valid;
    logic [AW-1:0] fail_addr;
    logic [BW-1:0] fail_bit;

    logic [DW-1:0] mem   [WORDS];
    logic [DW-1:0] fault [WORDS];
    logic [DW-1:0] exp_mem [WORDS];

    int n_total = 0;
    int n_fail  = 0;
    int fcnt;
    logic [AW-1:0] first_a, last_a;
    logic [BW-1:0] first_b, last_b;

    always #4 clk = ~clk;

    prbs_mbist dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_valid(fail_valid), .fail_addr(fail_addr), .fail_bit(fail_bit)
    );

    // memory model: write at the edge, registered read, faults on read only
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr] ^ fault[mem_addr];
    end

    // fail-log monitor
    always @(negedge clk) begin
        if (rst_n && fail_valid) begin
            if (fcnt == 0) begin
                first_a = fail_addr;
                first_b = fail_bit;
            end
            last_a = fail_addr;
            last_b = fail_bit;
            fcnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // stream model from the requirement text
    task automatic build_exp(input logic [6:0] sd);
        logic [6:0] s;
        logic       b;
        s = (sd == 7'h00) ? 7'h01 : sd;
        for (int a = 0; a < WORDS; a++) begin
            for (int j = 0; j < DW; j++) begin
                b = s[6] ^ s[5];
                s = {s[5:0], b};
                exp_mem[a][j] = b;
            end
        end
    endtask

    task automatic run_pass(input logic [6:0] sd, input logic [AW-1:0] fa,
                            input logic [DW-1:0] fm, input bit intrude);
        int n;
        int lo, hi;
        for (int a = 0; a < WORDS; a++) fault[a] = '0;
        fault[fa] = fm;
        fcnt = 0;
        build_exp(sd);
        @(negedge clk);
        seed  = sd;
        start = 1'b1;
        n = 0;
        while (!done || n == 0) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            seed  = sd;
            if (n == 1) begin
                check(busy == 1'b1, "R7 busy after start", int'(busy), 1);
                check(fail == 1'b0, "R6 fail cleared by start", int'(fail), 0);
            end
            if (intrude && n == 40) begin
                start = 1'b1;
                seed  = ~sd;
            end
            if (n > 2 * EXP_CYC) break;
        end
        check(n == EXP_CYC, "R7 done timing", n, EXP_CYC);
        for (int a = 0; a < WORDS; a++)
            check(mem[a] == exp_mem[a], "R2 stored word", int'(mem[a]), int'(exp_mem[a]));
        check(fcnt == $countones(fm), "R4 fail pulse count", fcnt, $countones(fm));
        check(fail == (fm != '0), "R6 sticky fail", int'(fail), int'(fm != '0));
        if (fm != '0) begin
            lo = -1;
            hi = 0;
            for (int j = 0; j < DW; j++) if (fm[j]) begin
                if (lo < 0) lo = j;
                hi = j;
            end
            check(first_a == fa, "R5 first fail address", int'(first_a), int'(fa));
            check(int'(first_b) == lo, "R5 first fail bit", int'(first_b), lo);
            check(int'(last_b) == hi, "R5 last fail bit", int'(last_b), hi);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        for (int a = 0; a < WORDS; a++) begin
            mem[a]   = '0;
            fault[a] = '0;
        end
        fcnt = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!busy && !done && !fail && !fail_valid && !mem_we, "R9 reset outputs",
              int'({busy, done, fail, fail_valid, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of passes; R1 stream rule checked through the stored words
        for (int v = 0; v < NVEC; v++)
            run_pass(VEC[v][18:12], VEC[v][11:8], VEC[v][7:0], 1'b0);

        // R3 zero seed equals seed 1
        build_exp(7'h01);
        check(mem[0] == exp_mem[0] && mem[WORDS-1] == exp_mem[WORDS-1],
              "R3 zero seed substitution", int'(mem[0]), int'(exp_mem[0]));

        // R8 start during fill is ignored
        run_pass(7'h11, 4'd9, 8'h42, 1'b1);

        // R9 reset in mid-pass
        @(negedge clk);
        seed  = 7'h2C;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !done && !fail && !mem_we, "R9 reset mid-pass",
              int'({busy, done, fail, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 failure on the final bit of the final word after reset
        run_pass(7'h2C, 4'd15, 8'h81, 1'b0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule